// File: doc/BRIEF.md
# Lockable Peripheral Pin Crossbar

This block is a routing matrix between a set of remappable pins and the digital peripherals of a chip. It handles the two directions differently. On the input side, every peripheral input owns a 4-bit select field that names the pin feeding it. On the output side, every pin owns a 4-bit select field that names the peripheral output driving it. An output select of zero means the pin belongs to the general-purpose I/O latch and direction register. A nonzero, valid select hands the pin's level and its output enable to the chosen peripheral. An analog selection on a pin beats all of this.

Software programs the select fields through a small register bus. A lock bit in a control register protects all select fields. While the lock is set, writes to those fields are accepted on the bus but change nothing. A one-way option is sampled from a static input during reset. When it is active, the lock cannot be cleared once it has been set, so the map can be programmed in only one session per reset.

Top module: `pxb_crossbar`

## Requirements
- R1: During reset every select field becomes 0 and the lock becomes 0. After reset every pin follows `gpio_lat`/`gpio_oe` with `pin_remapped` low.
- R2: The input select for peripheral input i lives at address 0x10+i. Its bits 3:0 hold the code. A code c below NUM_PINS drives `periph_in[i]` with `pin_in[c]`, whatever the pin direction. A read returns the code in bits 3:0 with all upper bits 0.
- R3: While the lock is 1, a write to any select address leaves every select field unchanged.
- R4: With the one-way option sampled as 1 at reset, once the lock has been set a write of 0 to it has no effect until the next reset. With the option sampled as 0, the lock follows control writes freely.
- R5: The output select for pin p lives at address 0x20+p. A code c with 1 ≤ c ≤ NUM_OUT makes `pin_out[p]` equal `periph_out[c-1]` and `pin_oe[p]` equal `periph_oe[c-1]`, with `pin_remapped[p]` high.
- R6: An output code of 0, or a code above NUM_OUT, leaves pin p on `gpio_lat[p]`/`gpio_oe[p]` with `pin_remapped[p]` low.
- R7: An input code of NUM_PINS or more routes a constant 0 to the peripheral input.
- R8: When `analog_sel[p]` is 1, `pin_out[p]`, `pin_oe[p]` and `pin_remapped[p]` are all 0, whatever the select field holds.
- R9: The control register is at address 0x00. Bit 0 is the lock (read/write) and bit 1 reads back the sampled one-way option. Any other address reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| one_way_cfg | input | 1 | Static one-way lock option, sampled during reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| pin_in | input | NUM_PINS | Levels currently present on the pins |
| gpio_lat | input | NUM_PINS | General-purpose output latch per pin |
| gpio_oe | input | NUM_PINS | General-purpose output enable per pin |
| analog_sel | input | NUM_PINS | Pin is claimed by an analog function |
| periph_out | input | NUM_OUT | Peripheral output levels |
| periph_oe | input | NUM_OUT | Peripheral output enables |
| periph_in | output | NUM_IN | Routed levels to the peripheral inputs |
| pin_out | output | NUM_PINS | Level to drive on each pin |
| pin_oe | output | NUM_PINS | Output enable for each pin |
| pin_remapped | output | NUM_PINS | Pin is driven by a peripheral through the crossbar |

## Verification
The assertions assume that `one_way_cfg` is held steady while reset is active. They also assume that `analog_sel`, the GPIO vectors and the peripheral vectors are settled levels, sampled at the clock like any other input. The stimulus changes every input only on the falling edge and changes `one_way_cfg` only inside a reset pulse. It produces the reserved input codes (8 to 15) and output codes (8 to 15) through random 4-bit fields. It raises `analog_sel` on roughly one pin in eight, so analog priority, GPIO pass-through and peripheral override all occur in the same run.

// File: rtl/pxb_pkg.sv
// Package for the pin crossbar: select-field type, register address layout.
// Assumes a 6-bit register address whose upper two bits pick a region.
package pxb_pkg;
    localparam int SEL_W  = 4;
    localparam int ADDR_W = 6;
    localparam int IDX_W  = 4;

    typedef logic [SEL_W-1:0] sel_t;

    typedef enum logic [1:0] {
        RGN_CTRL   = 2'b00,
        RGN_INMAP  = 2'b01,
        RGN_OUTMAP = 2'b10,
        RGN_NONE   = 2'b11
    } region_e;
endpackage

// File: rtl/pxb_regs.sv
// Register file of the crossbar: input selects, output selects, lock and one-way flag.
// Assumes one_way_cfg is stable while rst_n is low; writes land on the rising edge.
module pxb_regs
    import pxb_pkg::*;
#(
    parameter int NUM_IN   = 8,
    parameter int NUM_PINS = 8,
    parameter int DATA_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 one_way_cfg,
    input  logic                 reg_we,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output sel_t [NUM_IN-1:0]    in_sel,
    output sel_t [NUM_PINS-1:0]  out_sel,
    output logic                 lock,
    output logic                 one_way
);
    region_e          region;
    logic [IDX_W-1:0] idx;
    logic             ctrl_hit;
    logic             map_we;

    // Split the address into region and index
    always_comb begin
        region   = region_e'(reg_addr[ADDR_W-1:IDX_W]);
        idx      = reg_addr[IDX_W-1:0];
        ctrl_hit = (region == RGN_CTRL) && (idx == '0);
        map_we   = reg_we && !lock;
    end

    // Lock bit and one-way option; the option is captured during reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock    <= 1'b0;
            one_way <= one_way_cfg;
        end else if (reg_we && ctrl_hit) begin
            if (!(lock && one_way)) begin
                lock <= reg_wdata[0];
            end
        end
    end

    // One select register per peripheral input
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                in_sel[gi] <= '0;
            end else if (map_we && region == RGN_INMAP && idx == IDX_W'(gi)) begin
                in_sel[gi] <= reg_wdata[SEL_W-1:0];
            end
        end
    end

    // One select register per remappable pin
    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_out
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                out_sel[gp] <= '0;
            end else if (map_we && region == RGN_OUTMAP && idx == IDX_W'(gp)) begin
                out_sel[gp] <= reg_wdata[SEL_W-1:0];
            end
        end
    end

    // Read mux; fields are zero-extended, unused addresses read zero
    always_comb begin
        reg_rdata = '0;
        unique case (region)
            RGN_CTRL: begin
                if (ctrl_hit) begin
                    reg_rdata[0] = lock;
                    reg_rdata[1] = one_way;
                end
            end
            RGN_INMAP: begin
                for (int k = 0; k < NUM_IN; k++) begin
                    if (idx == IDX_W'(k)) reg_rdata[SEL_W-1:0] = in_sel[k];
                end
            end
            RGN_OUTMAP: begin
                for (int k = 0; k < NUM_PINS; k++) begin
                    if (idx == IDX_W'(k)) reg_rdata[SEL_W-1:0] = out_sel[k];
                end
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/pxb_in_route.sv
// Input side: for each peripheral input, pick one pin by its select code.
// Assumes codes at or above NUM_PINS are reserved and yield a constant 0.
module pxb_in_route
    import pxb_pkg::*;
#(
    parameter int NUM_IN   = 8,
    parameter int NUM_PINS = 8
) (
    input  sel_t [NUM_IN-1:0]   in_sel,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_IN-1:0]   periph_in
);
    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_mux
        // Compare the select against every pin number; no match gives 0
        always_comb begin
            periph_in[gi] = 1'b0;
            for (int k = 0; k < NUM_PINS; k++) begin
                if (in_sel[gi] == SEL_W'(k)) periph_in[gi] = pin_in[k];
            end
        end
    end
endmodule

// File: rtl/pxb_out_route.sv
// Output side: for each pin, choose GPIO or one peripheral output and its enable.
// Assumes code 0 and codes above NUM_OUT mean "no connection"; analog always wins.
module pxb_out_route
    import pxb_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int NUM_OUT  = 7
) (
    input  sel_t [NUM_PINS-1:0] out_sel,
    input  logic [NUM_PINS-1:0] gpio_lat,
    input  logic [NUM_PINS-1:0] gpio_oe,
    input  logic [NUM_PINS-1:0] analog_sel,
    input  logic [NUM_OUT-1:0]  periph_out,
    input  logic [NUM_OUT-1:0]  periph_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_remapped
);
    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin
        logic hit;
        logic src_d;
        logic src_oe;

        // Find the peripheral whose code (index + 1) matches the select
        always_comb begin
            hit    = 1'b0;
            src_d  = 1'b0;
            src_oe = 1'b0;
            for (int k = 0; k < NUM_OUT; k++) begin
                if (out_sel[gp] == SEL_W'(k + 1)) begin
                    hit    = 1'b1;
                    src_d  = periph_out[k];
                    src_oe = periph_oe[k];
                end
            end
        end

        // Priority: analog, then crossbar peripheral, then GPIO
        always_comb begin
            if (analog_sel[gp]) begin
                pin_out[gp]      = 1'b0;
                pin_oe[gp]       = 1'b0;
                pin_remapped[gp] = 1'b0;
            end else if (hit) begin
                pin_out[gp]      = src_d;
                pin_oe[gp]       = src_oe;
                pin_remapped[gp] = 1'b1;
            end else begin
                pin_out[gp]      = gpio_lat[gp];
                pin_oe[gp]       = gpio_oe[gp];
                pin_remapped[gp] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pxb_crossbar.sv
// Top of the lockable pin crossbar: registers plus input and output routing.
// Assumes a single clock; routing outputs are combinational from the select registers.
module pxb_crossbar
    import pxb_pkg::*;
#(
    parameter int NUM_IN   = 8,
    parameter int NUM_PINS = 8,
    parameter int NUM_OUT  = 7,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                one_way_cfg,
    input  logic                reg_we,
    input  logic [5:0]          reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] gpio_lat,
    input  logic [NUM_PINS-1:0] gpio_oe,
    input  logic [NUM_PINS-1:0] analog_sel,
    input  logic [NUM_OUT-1:0]  periph_out,
    input  logic [NUM_OUT-1:0]  periph_oe,
    output logic [NUM_IN-1:0]   periph_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_remapped
);
    sel_t [NUM_IN-1:0]   in_sel;
    sel_t [NUM_PINS-1:0] out_sel;
    logic                lock;
    logic                one_way;

    pxb_regs #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .one_way_cfg(one_way_cfg),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .in_sel(in_sel), .out_sel(out_sel),
        .lock(lock), .one_way(one_way)
    );

    pxb_in_route #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS)) u_in (
        .in_sel(in_sel), .pin_in(pin_in), .periph_in(periph_in)
    );

    pxb_out_route #(.NUM_PINS(NUM_PINS), .NUM_OUT(NUM_OUT)) u_out (
        .out_sel(out_sel), .gpio_lat(gpio_lat), .gpio_oe(gpio_oe),
        .analog_sel(analog_sel), .periph_out(periph_out), .periph_oe(periph_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_remapped(pin_remapped)
    );
endmodule

// File: rtl/pxb_checks.sv
// Property checker for the pin crossbar, bound into every pxb_crossbar instance.
// Assumes one_way_cfg is held steady while reset is low.
module pxb_checks
    import pxb_pkg::*;
#(
    parameter int NUM_IN   = 8,
    parameter int NUM_PINS = 8,
    parameter int NUM_OUT  = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic                lock,
    input logic                one_way,
    input sel_t [NUM_IN-1:0]   in_sel,
    input sel_t [NUM_PINS-1:0] out_sel,
    input logic [NUM_PINS-1:0] gpio_lat,
    input logic [NUM_PINS-1:0] gpio_oe,
    input logic [NUM_PINS-1:0] analog_sel,
    input logic [NUM_IN-1:0]   periph_in,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_remapped
);
    AST_LOCKED_MAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && reg_we) |=> ($stable(in_sel) && $stable(out_sel))); // R3

    AST_ONE_WAY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (one_way && lock) |=> lock); // R4

    for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_in_chk
        AST_RESERVED_IN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(in_sel[gi]) >= NUM_PINS) |-> !periph_in[gi]); // R7
    end

    for (genvar gp = 0; gp < NUM_PINS; gp++) begin : g_pin_chk
        AST_ANALOG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            analog_sel[gp] |-> (!pin_out[gp] && !pin_oe[gp] && !pin_remapped[gp])); // R8

        AST_UNMAPPED_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
            (out_sel[gp] == '0 && !analog_sel[gp]) |->
            (pin_out[gp] == gpio_lat[gp] && pin_oe[gp] == gpio_oe[gp] && !pin_remapped[gp])); // R6
    end
endmodule

bind pxb_crossbar pxb_checks #(.NUM_IN(NUM_IN), .NUM_PINS(NUM_PINS), .NUM_OUT(NUM_OUT)) u_pxb_checks (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .lock(lock), .one_way(one_way),
    .in_sel(in_sel), .out_sel(out_sel), .gpio_lat(gpio_lat), .gpio_oe(gpio_oe),
    .analog_sel(analog_sel), .periph_in(periph_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_remapped(pin_remapped)
);

// File: tb/pxb_crossbar_test.sv
`timescale 1ns/1ps
module pxb_crossbar_test;
    localparam int NI = 8;
    localparam int NP = 8;
    localparam int NO = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          one_way_cfg = 1'b0;
    logic          reg_we = 1'b0;
    logic [5:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0, gpio_lat = '0, gpio_oe = '0, analog_sel = '0;
    logic [NO-1:0] periph_out = '0, periph_oe = '0;
    logic [NI-1:0] periph_in;
    logic [NP-1:0] pin_out, pin_oe, pin_remapped;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [3:0] m_in [NI];
    logic [3:0] m_out [NP];
    logic       m_lock, m_ow;

    always #2 clk = ~clk;

    pxb_crossbar #(.NUM_IN(NI), .NUM_PINS(NP), .NUM_OUT(NO)) uut (.*);

    // Expected register read value from the bench model
    function automatic logic [31:0] exp_read(input logic [5:0] a);
        logic [31:0] r = '0;
        if (a == 6'h00) r = {30'b0, m_ow, m_lock};
        else if (a[5:4] == 2'b01 && int'(a[3:0]) < NI) r[3:0] = m_in[a[3:0]];
        else if (a[5:4] == 2'b10 && int'(a[3:0]) < NP) r[3:0] = m_out[a[3:0]];
        return r;
    endfunction

    function automatic logic exp_pin_in(input int i);
        return (int'(m_in[i]) < NP) ? pin_in[m_in[i]] : 1'b0;
    endfunction

    function automatic logic [2:0] exp_pin(input int p);
        int c = int'(m_out[p]);
        if (analog_sel[p]) return 3'b000;
        if (c >= 1 && c <= NO) return {1'b1, periph_oe[c-1], periph_out[c-1]};
        return {1'b0, gpio_oe[p], gpio_lat[p]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        for (int i = 0; i < NI; i++)
            check((int'(m_in[i]) < NP) ? "R2" : "R7", 32'(periph_in[i]), 32'(exp_pin_in(i)));
        for (int p = 0; p < NP; p++) begin
            logic [2:0] e = exp_pin(p);
            string tag = analog_sel[p] ? "R8" : (e[2] ? "R5" : "R6");
            check(tag, 32'({pin_remapped[p], pin_oe[p], pin_out[p]}), 32'(e));
        end
    endtask

    task automatic rd_check(input logic [5:0] a, input string req);
        reg_addr = a;
        #0.5;
        check(req, reg_rdata, exp_read(a));
    endtask

    task automatic model_write(input logic [5:0] a, input logic [31:0] d);
        if (a == 6'h00) begin
            if (!(m_lock && m_ow)) m_lock = d[0];
        end else if (!m_lock) begin
            if (a[5:4] == 2'b01 && int'(a[3:0]) < NI) m_in[a[3:0]] = d[3:0];
            if (a[5:4] == 2'b10 && int'(a[3:0]) < NP) m_out[a[3:0]] = d[3:0];
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk);
        #1;
        reg_we = 1'b0;
        model_write(a, d);
    endtask

    task automatic do_reset(input logic ow);
        @(negedge clk);
        rst_n = 1'b0; one_way_cfg = ow;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_lock = 1'b0; m_ow = ow;
        for (int i = 0; i < NI; i++) m_in[i] = '0;
        for (int p = 0; p < NP; p++) m_out[p] = '0;
        #0.5;
    endtask

    task automatic rand_inputs();
        pin_in = NP'($urandom); gpio_lat = NP'($urandom); gpio_oe = NP'($urandom);
        periph_out = NO'($urandom); periph_oe = NO'($urandom);
        analog_sel = '0;
        for (int p = 0; p < NP; p++) analog_sel[p] = ($urandom % 8) == 0;
    endtask

    task automatic rand_phase(input int n);
        for (int it = 0; it < n; it++) begin
            int kind = $urandom % 16;
            logic [5:0] a;
            if (kind == 0) a = 6'h00;
            else if (kind < 7) a = {2'b01, 4'($urandom % NI)};
            else if (kind < 13) a = {2'b10, 4'($urandom % NP)};
            else a = 6'($urandom);
            @(negedge clk);
            rand_inputs();
            wr(a, $urandom);
            check_outputs();
            rd_check(6'($urandom), "R9");
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        // R1: reset state
        gpio_lat = 8'hA5; gpio_oe = 8'h3C;
        do_reset(1'b0);
        rd_check(6'h00, "R1");
        for (int i = 0; i < NI; i++) rd_check({2'b01, 4'(i)}, "R1");
        for (int p = 0; p < NP; p++) rd_check({2'b10, 4'(p)}, "R1");
        check("R1", 32'({pin_remapped, pin_oe, pin_out}), 32'({8'h00, 8'h3C, 8'hA5}));

        // R2: input code 3 sees pin 3 regardless of direction; upper bits read 0
        wr(6'h10, 32'hFFFF_FFF3);
        pin_in = 8'b0000_1000; #0.5;
        check("R2", 32'(periph_in[0]), 32'd1);
        rd_check(6'h10, "R2");
        // R7: reserved input code gives 0 even with all pins high
        wr(6'h11, 32'h9);
        pin_in = 8'hFF; #0.5;
        check("R7", 32'(periph_in[1]), 32'd0);

        // R5: pin 2 driven by peripheral code 7 (index 6)
        wr(6'h22, 32'h7);
        periph_out = 7'b100_0000; periph_oe = 7'b100_0000; analog_sel = '0; #0.5;
        check("R5", 32'({pin_remapped[2], pin_oe[2], pin_out[2]}), 32'b111);
        // R8: analog overrides
        analog_sel = 8'b0000_0100; #0.5;
        check("R8", 32'({pin_remapped[2], pin_oe[2], pin_out[2]}), 32'b000);
        analog_sel = '0;
        // R6: reserved output code 8 leaves pin on GPIO
        wr(6'h22, 32'h8);
        check("R6", 32'({pin_remapped[2], pin_oe[2], pin_out[2]}), {29'b0, 1'b0, gpio_oe[2], gpio_lat[2]});

        // R3: locked writes dropped
        wr(6'h00, 32'h1);
        wr(6'h10, 32'h5);
        wr(6'h25, 32'h2);
        rd_check(6'h10, "R3");
        rd_check(6'h25, "R3");
        check("R3", reg_rdata, 32'h0);
        // R4: without one-way, unlock works
        wr(6'h00, 32'h0);
        rd_check(6'h00, "R4");
        check("R4", reg_rdata, 32'h0);
        // R9: unused addresses read 0 and write nothing
        wr(6'h3F, 32'hF);
        wr(6'h01, 32'hF);
        rd_check(6'h3F, "R9");
        rd_check(6'h18, "R9");
        for (int i = 0; i < NI; i++) rd_check({2'b01, 4'(i)}, "R9");

        rand_phase(400);

        // R4: one-way lock is sticky until reset
        do_reset(1'b1);
        wr(6'h12, 32'h4);
        wr(6'h00, 32'h1);
        wr(6'h00, 32'h0);
        rd_check(6'h00, "R4");
        check("R4", reg_rdata, 32'h3);
        wr(6'h12, 32'h6);
        rd_check(6'h12, "R4");
        rand_phase(150);
        do_reset(1'b1);
        rd_check(6'h00, "R4");
        rand_phase(150);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule